// File: doc/BRIEF.md
# Thermistor Resistance Tracking Loop

This block closes a digital loop around an external current source and comparator that bias a negative-temperature-coefficient thermistor. Each step moves an 8-bit current code so that the thermistor node settles on a fixed reference voltage. At balance the code is proportional to the thermistor's conductance, roughly four million divided by the total resistance in ohms. A larger code therefore means a lower resistance and a hotter board.

After power-up a startup mode moves the code one step per clock. This settles the loop in well under five milliseconds. Converter startup is held off until the loop has had time to settle and the code reads cooler than the release level. In normal running the loop steps once every seventh half line-cycle, which keeps the code quiet.

Two first-order filters follow the code, and both are clocked by the half-line strobe. The short filter feeds a non-latched overtemperature shutdown with hysteresis. The long filter, with a time constant of minutes, feeds a linear derating of the output scale.

Top module: `ntc_track`

## Requirements
- R1: While reset is held, the code, both filtered codes and the shutdown flag are 0, the startup permit is 0 and the scale output is 100.
- R2: With `startup_i` low, the code moves by exactly one LSB on every seventh `half_cyc_i` pulse. It decrements when `cmp_above_i` is 1 and increments when `cmp_above_i` is 0.
- R3: With `startup_i` low and `half_cyc_i` low, the code does not change, whatever `cmp_above_i` does.
- R4: With `startup_i` high, the code steps once per clock in the direction given by `cmp_above_i`, and the half-cycle divider is cleared. The first seventh pulse after startup is therefore the seventh pulse counted from the end of startup.
- R5: The code saturates: it stays at 0 when asked to decrement and at 255 when asked to increment.
- R6: While `startup_i` is high, both filters are loaded with the new code at each clock. Otherwise each filter updates only on a `half_cyc_i` pulse as acc += code − (acc >> shift), and its output is acc >> shift.
- R7: The shutdown flag is set one clock after the short filtered code exceeds `C_SHDN` (default 190).
- R8: The shutdown flag clears one clock after the short filtered code drops below `C_REL` (default 150). Between the two levels it holds its value, and the code keeps tracking while the flag is set.
- R9: `start_ok_o` is 1 only once `startup_i` has been high for `SETTLE` clocks (default 256) in total and the code is below `C_REL`.
- R10: The scale output is 100 when the long filtered code is at or below `C_DER_LO` (default 120) and 50 at or above `C_DER_HI` (default 180). In between it is 100 − ⌊50·(f − 120)/60⌋; for example f = 150 gives 75.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above_i | input | 1 | Comparator: thermistor node above the reference |
| half_cyc_i | input | 1 | One-clock pulse per rectified half line-cycle |
| startup_i | input | 1 | High selects fast startup tracking |
| code_o | output | 8 | Current-source code (conductance) |
| filt_code_o | output | 8 | Short filtered code used for shutdown |
| slow_code_o | output | 8 | Long filtered code used for derating |
| otp_shdn_o | output | 1 | Overtemperature shutdown, non-latched |
| start_ok_o | output | 1 | Converter startup permitted |
| scale_o | output | 7 | Output scale in percent (50 to 100) |

## Verification
The loop is first driven with comparator runs in fast mode: runs pinned against 0 and against 255, and long one-direction runs. These separate per-clock stepping from saturation.

Normal-mode runs of strobes then show the divide-by-seven pacing. Runs in which the comparator toggles with no strobe show that the code holds. Preset codes at 105, 150, 180 and 205 pin the derating at its flat, linear and clamped parts, and make the shutdown flag set.

A slow strobe-driven descent from 205 shows that the flag holds between the two levels and then clears. It also shows that the short filter lags the code by exactly one update.

// File: rtl/ntc_track_pkg.sv
package ntc_track_pkg;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned SCALE_W = 7;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [SCALE_W-1:0] scale_t;

  function automatic code_t step_code(input code_t cur, input logic dn);
    code_t r;
    if (dn) r = (cur == '0) ? cur : cur - code_t'(1);
    else    r = (cur == '1) ? cur : cur + code_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/ntc_step_ctrl.sv
module ntc_step_ctrl
  import ntc_track_pkg::*;
#(
  parameter int unsigned DIV    = 7,
  parameter int unsigned SETTLE = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  startup_i,
  input  logic  cmp_above_i,
  input  logic  half_cyc_i,
  output code_t code_q_o,
  output code_t code_d_o,
  output logic  settled_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned SW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] settle_q, settle_d;
  code_t         code_q, code_d;
  logic          step_en;

  assign settled_o = (settle_q == SW'(SETTLE));

  always_comb begin
    step_en  = 1'b0;
    cnt_d    = cnt_q;
    settle_d = settle_q;
    if (startup_i) begin
      step_en = 1'b1;
      cnt_d   = '0;
      if (!settled_o) settle_d = settle_q + SW'(1);
    end else if (half_cyc_i) begin
      if (cnt_q == CW'(DIV - 1)) begin
        cnt_d   = '0;
        step_en = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    code_d = step_en ? step_code(code_q, cmp_above_i) : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      settle_q <= '0;
      code_q   <= '0;
    end else begin
      cnt_q    <= cnt_d;
      settle_q <= settle_d;
      code_q   <= code_d;
    end
  end

  assign code_q_o = code_q;
  assign code_d_o = code_d;
endmodule

// File: rtl/ntc_iir.sv
module ntc_iir
  import ntc_track_pkg::*;
#(
  parameter int unsigned SH = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  code_t load_val_i,
  input  logic  en_i,
  input  code_t din_i,
  output code_t dout_o
);
  localparam int unsigned ACC_W = CODE_W + SH;

  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (load_i)    acc_d = {load_val_i, {SH{1'b0}}};
    else if (en_i) acc_d = acc_q - (acc_q >> SH) + ACC_W'(din_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign dout_o = acc_q[ACC_W-1:SH];
endmodule

// File: rtl/ntc_derate.sv
module ntc_derate
  import ntc_track_pkg::*;
#(
  parameter int unsigned C_LO  = 120,
  parameter int unsigned C_HI  = 180,
  parameter int unsigned S_MAX = 100,
  parameter int unsigned S_MIN = 50
) (
  input  code_t  filt_i,
  output scale_t scale_o
);
  localparam int unsigned SPAN = C_HI - C_LO;
  localparam int unsigned DROP = S_MAX - S_MIN;

  int unsigned diff, cut;

  always_comb begin
    diff = 32'(filt_i) - C_LO;
    cut  = (DROP * diff) / SPAN;
    if (32'(filt_i) <= C_LO)      scale_o = scale_t'(S_MAX);
    else if (32'(filt_i) >= C_HI) scale_o = scale_t'(S_MIN);
    else                          scale_o = scale_t'(S_MAX - cut);
  end
endmodule

// File: rtl/ntc_track.sv
module ntc_track
  import ntc_track_pkg::*;
#(
  parameter int unsigned DIV      = 7,
  parameter int unsigned SETTLE   = 256,
  parameter int unsigned FAST_SH  = 3,
  parameter int unsigned SLOW_SH  = 14,
  parameter int unsigned C_DER_LO = 120,
  parameter int unsigned C_REL    = 150,
  parameter int unsigned C_DER_HI = 180,
  parameter int unsigned C_SHDN   = 190
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_above_i,
  input  logic       half_cyc_i,
  input  logic       startup_i,
  output logic [7:0] code_o,
  output logic [7:0] filt_code_o,
  output logic [7:0] slow_code_o,
  output logic       otp_shdn_o,
  output logic       start_ok_o,
  output logic [6:0] scale_o
);
  localparam code_t REL_C  = code_t'(C_REL);
  localparam code_t SHDN_C = code_t'(C_SHDN);

  logic [1:0] rst_sync_q;
  logic       rst_i;
  code_t      code_q, code_d, filt_fast, filt_slow;
  logic       settled, filt_en;
  logic       otp_q, otp_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  ntc_step_ctrl #(.DIV(DIV), .SETTLE(SETTLE)) u_step (
    .clk        (clk),
    .rst_n      (rst_i),
    .startup_i  (startup_i),
    .cmp_above_i(cmp_above_i),
    .half_cyc_i (half_cyc_i),
    .code_q_o   (code_q),
    .code_d_o   (code_d),
    .settled_o  (settled)
  );

  assign filt_en = half_cyc_i & ~startup_i;

  ntc_iir #(.SH(FAST_SH)) u_fast (
    .clk(clk), .rst_n(rst_i), .load_i(startup_i), .load_val_i(code_d),
    .en_i(filt_en), .din_i(code_q), .dout_o(filt_fast)
  );

  ntc_iir #(.SH(SLOW_SH)) u_slow (
    .clk(clk), .rst_n(rst_i), .load_i(startup_i), .load_val_i(code_d),
    .en_i(filt_en), .din_i(code_q), .dout_o(filt_slow)
  );

  ntc_derate #(.C_LO(C_DER_LO), .C_HI(C_DER_HI), .S_MAX(100), .S_MIN(50)) u_derate (
    .filt_i (filt_slow),
    .scale_o(scale_o)
  );

  always_comb begin
    otp_d = otp_q;
    if (filt_fast > SHDN_C)     otp_d = 1'b1;
    else if (filt_fast < REL_C) otp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) otp_q <= 1'b0;
    else        otp_q <= otp_d;
  end

  assign code_o      = code_q;
  assign filt_code_o = filt_fast;
  assign slow_code_o = filt_slow;
  assign otp_shdn_o  = otp_q;
  assign start_ok_o  = settled & (code_q < REL_C);
endmodule

// File: rtl/ntc_track_chk.sv
module ntc_track_chk #(
  parameter int unsigned C_REL  = 150,
  parameter int unsigned C_SHDN = 190
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_above_i,
  input logic       half_cyc_i,
  input logic       startup_i,
  input logic [7:0] code_o,
  input logic [7:0] filt_code_o,
  input logic [7:0] slow_code_o,
  input logic       otp_shdn_o,
  input logic [6:0] scale_o
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !startup_i |=> (code_o == $past(code_o) || code_o == $past(code_o) + 8'd1 ||
                    code_o == $past(code_o) - 8'd1)); // R2
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!startup_i && !half_cyc_i) |=> $stable(code_o)); // R3
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_i && !cmp_above_i && code_o == 8'hFF) |=> code_o == 8'hFF); // R5
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_i && cmp_above_i && code_o == 8'h00) |=> code_o == 8'h00); // R5
  AST_FILT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    startup_i |=> (filt_code_o == code_o && slow_code_o == code_o)); // R6
  AST_OTP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(filt_code_o) > C_SHDN) |=> otp_shdn_o); // R7
  AST_OTP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(filt_code_o) < C_REL) |=> !otp_shdn_o); // R8
  AST_SCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_o >= 7'd50 && scale_o <= 7'd100)); // R10
endmodule

bind ntc_track ntc_track_chk #(.C_REL(C_REL), .C_SHDN(C_SHDN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_above_i(cmp_above_i), .half_cyc_i(half_cyc_i),
  .startup_i(startup_i), .code_o(code_o), .filt_code_o(filt_code_o),
  .slow_code_o(slow_code_o), .otp_shdn_o(otp_shdn_o), .scale_o(scale_o)
);

// File: tb/ntc_track_bench.sv
module ntc_track_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmp_above_i, half_cyc_i, startup_i;
  logic [7:0] code_o, filt_code_o, slow_code_o;
  logic       otp_shdn_o, start_ok_o;
  logic [6:0] scale_o;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ntc_track #(.SLOW_SH(2)) u_ntc_track (
    .clk(clk), .rst_n(rst_n), .cmp_above_i(cmp_above_i), .half_cyc_i(half_cyc_i),
    .startup_i(startup_i), .code_o(code_o), .filt_code_o(filt_code_o),
    .slow_code_o(slow_code_o), .otp_shdn_o(otp_shdn_o), .start_ok_o(start_ok_o),
    .scale_o(scale_o)
  );

  // {req[3:0], startup, cmp_above, strobe, count[8:0], expected code[7:0]}
  localparam logic [23:0] VEC [8] = '{
    {4'd5, 1'b1, 1'b1, 1'b0, 9'd3,   8'd0},   // R5 pinned at 0
    {4'd4, 1'b1, 1'b0, 1'b0, 9'd100, 8'd100}, // R4 one step per clock
    {4'd4, 1'b1, 1'b1, 1'b0, 9'd10,  8'd90},  // R4 downward
    {4'd2, 1'b0, 1'b0, 1'b1, 9'd6,   8'd90},  // R2 six pulses, no step
    {4'd2, 1'b0, 1'b0, 1'b1, 9'd1,   8'd91},  // R2 seventh pulse steps
    {4'd3, 1'b0, 1'b1, 1'b0, 9'd20,  8'd91},  // R3 no strobe, held
    {4'd2, 1'b0, 1'b1, 1'b1, 9'd14,  8'd89},  // R2 two steps down
    {4'd5, 1'b1, 1'b0, 1'b0, 9'd200, 8'd255}  // R5 pinned at 255
  };

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fast_to(input int tgt);
    startup_i  = 1'b1;
    half_cyc_i = 1'b0;
    while (int'(code_o) != tgt) begin
      cmp_above_i = (int'(code_o) > tgt);
      cyc();
    end
    startup_i = 1'b0;
    cyc();
    cyc();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmp_above_i = 1'b0; half_cyc_i = 1'b0; startup_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 code", int'(code_o), 0);
    check("R1 filt", int'(filt_code_o), 0);
    check("R1 otp", int'(otp_shdn_o), 0);
    check("R1 start_ok", int'(start_ok_o), 0);
    check("R1 scale", int'(scale_o), 100);
    rst_n = 1'b1;
    repeat (3) cyc();

    for (int i = 0; i < 8; i++) begin
      startup_i   = VEC[i][19];
      cmp_above_i = VEC[i][18];
      half_cyc_i  = VEC[i][17];
      repeat (int'(VEC[i][16:8])) cyc();
      check($sformatf("R%0d vector %0d code", VEC[i][23:20], i), int'(code_o), int'(VEC[i][7:0]));
      if (i == 2) check("R9 not yet settled", int'(start_ok_o), 0);
    end
    check("R9 hot code blocks start", int'(start_ok_o), 0);

    fast_to(105);
    check("R9 start permitted", int'(start_ok_o), 1);
    check("R6 filt after load", int'(filt_code_o), 105);
    check("R8 otp cleared after cooling", int'(otp_shdn_o), 0);
    check("R10 flat scale", int'(scale_o), 100);

    fast_to(150);
    check("R10 linear scale", int'(scale_o), 75);
    check("R9 at release level", int'(start_ok_o), 0);

    fast_to(180);
    check("R10 scale at 50", int'(scale_o), 50);
    check("R7 below trip", int'(otp_shdn_o), 0);

    fast_to(205);
    check("R7 trip", int'(otp_shdn_o), 1);
    check("R10 clamp", int'(scale_o), 50);

    cmp_above_i = 1'b1;
    half_cyc_i  = 1'b1;
    repeat (7) cyc();
    check("R8 tracking in shutdown", int'(code_o), 204);
    check("R6 filter lag", int'(filt_code_o), 205);
    repeat (1) cyc();
    check("R6 filter update", int'(filt_code_o), 204);
    repeat (230) cyc();
    check("R2 descent code", int'(code_o), 171);
    check("R8 hold between levels", int'(otp_shdn_o), 1);

    half_cyc_i = 1'b0;
    begin
      automatic int f0 = int'(filt_code_o);
      for (int k = 0; k < 20; k++) begin
        cmp_above_i = k[0];
        cyc();
      end
      check("R6 filter idle without strobe", int'(filt_code_o), f0);
      check("R3 code idle without strobe", int'(code_o), 171);
    end

    cmp_above_i = 1'b1;
    half_cyc_i  = 1'b1;
    repeat (210) cyc();
    half_cyc_i = 1'b0;
    cyc();
    check("R2 descent code 2", int'(code_o), 141);
    check("R8 release", int'(otp_shdn_o), 0);

    rst_n = 1'b0;
    #3;
    check("R1 async reset code", int'(code_o), 0);
    check("R1 async reset otp", int'(otp_shdn_o), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule